// File: doc/BRIEF.md
# Word-Parallel Radix-2 Montgomery Multiplier

The block computes the Montgomery product R = X·Y·2^(-N) mod M for an odd N-bit modulus M and operands X, Y below M. The running sum is split into E = ceil((N+1)/W) words of W bits. Each word has its own processing element, which owns that word for the whole operation. X is taken one bit per iteration. Each bit, together with the parity bit that word 0 derives from it, travels along the elements through a pair of shift registers. Element j therefore runs iteration i exactly j cycles after element 0 does.

Each element needs the top bit of its own word from the previous iteration. That bit is only produced by the next element in the same cycle. The element therefore forms two candidate sums, one for each value of that bit, and picks between them at the end of the cycle. This keeps the skew between neighbours at a single cycle. The whole product takes N+E-1 cycles. The sum that leaves the array is below 2M. A last combinational step subtracts M once when needed, so the result is fully reduced.

A user pulses `start` with the operands on the inputs and waits for `done`. The result stays valid from then on until the next accepted start.

Top module: `mont_wp_mul`

## Requirements
- R1: For odd M and X, Y < M, the result after `done` equals X·Y·2^(-N) mod M and is strictly below M (N=64 by default).
- R2: X, Y and M are captured only at the clock edge that accepts `start`. Later changes on those inputs do not affect the running product.
- R3: `done` is high for exactly one cycle. It rises N+E-1 clock edges after the edge that accepted `start`, which is 68 edges for N=64, W=16 (E=5).
- R4: A `start` seen while a product is in progress is ignored. No restart happens, the result belongs to the first operands, and only one `done` pulse appears.
- R5: Once `done` has pulsed, `result` holds its value, whatever the operand inputs do, until the next accepted `start`.
- R6: After synchronous reset, `done` is 0 and `result` is 0.
- R7: A `start` given in the same cycle that `done` is high is accepted, and that product completes with the normal latency and a correct value.
- R8: A zero operand gives a zero result, and M = 1 gives a zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; accepted only when idle |
| x_in | input | N | Multiplier operand, scanned bit by bit |
| y_in | input | N | Multiplicand operand |
| m_in | input | N | Odd modulus |
| done | output | 1 | One-cycle completion pulse |
| result | output | N | Reduced Montgomery product |

## Verification
The internal checks assume that M is odd and that X and Y are below M. Under those conditions, bit 0 of word 0 always comes out zero after each iteration, the top word never carries beyond one bit, and the final value is below M. The bench builds every modulus by forcing its low bit to one and reduces each random operand modulo M before use. Edge values are kept within the same bounds: M = 1, M = 2^64-1, and operands of M-1. Expected products come from a separate route: the plain 128-bit product taken modulo M, times the inverse of 2^64 found by repeated halving modulo M.

// File: rtl/mont_pkg.sv
package mont_pkg;

    // Number of W-bit words needed to hold a value below 2^(N+1).
    function automatic int word_count(input int nbits, input int wbits);
        return (nbits + wbits) / wbits;
    endfunction

    // One iteration token moving along the element array.
    typedef struct packed {
        logic valid;   // element performs an iteration this cycle
        logic last;    // this is iteration N-1
        logic xbit;    // bit of X for this iteration
        logic qbit;    // parity decision made by word 0
    } step_t;

endpackage

// File: rtl/mont_step_feed.sv
module mont_step_feed
    import mont_pkg::*;
#(
    parameter int N = 64,
    parameter int E = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [N-1:0]     x_val,
    input  logic             s0_lsb,
    input  logic             y0_lsb,
    output step_t [E-1:0]    steps
);
    localparam int CW = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]     xsr;
    logic [CW-1:0]    iter;
    logic             feeding;
    step_t            head;
    step_t [E-1:1]    stg;

    // Word 0 decides whether M is added: parity of S + x*Y.
    always_comb begin
        head.valid = feeding;
        head.last  = feeding && (iter == CW'(N - 1));
        head.xbit  = xsr[0];
        head.qbit  = feeding & (s0_lsb ^ (xsr[0] & y0_lsb));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xsr     <= '0;
            iter    <= '0;
            feeding <= 1'b0;
        end else if (load) begin
            xsr     <= x_val;
            iter    <= '0;
            feeding <= 1'b1;
        end else if (feeding) begin
            xsr  <= xsr >> 1;
            iter <= iter + 1'b1;
            if (iter == CW'(N - 1))
                feeding <= 1'b0;
        end
    end

    // One-cycle skew per element for both the X bit and the parity bit.
    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg[1] <= head;
            for (int j = 2; j < E; j++)
                stg[j] <= stg[j-1];
        end
    end

    always_comb begin
        steps[0] = head;
        for (int j = 1; j < E; j++)
            steps[j] = stg[j];
    end

    // R4: the top never reloads the bit stream while it is still running.
    a_r4_no_reload: assert property (@(posedge clk) disable iff (rst)
        load |-> !feeding);

endmodule

// File: rtl/mont_word_pe.sv
module mont_word_pe
    import mont_pkg::*;
#(
    parameter int W   = 16,
    parameter bit TOP = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  step_t        step,
    input  logic [W-1:0] y_word,
    input  logic [W-1:0] m_word,
    input  logic [1:0]   cin,
    input  logic         nb_in,
    output logic         lsb_out,
    output logic [1:0]   carry_q,
    output logic [W-2:0] sh_q,
    output logic         lsb_q
);
    localparam int SW = W + 2;

    logic          top_bit;
    logic [SW-1:0] part;
    logic [SW-1:0] sum_lo;
    logic [SW-1:0] sum_hi;
    logic [SW-1:0] pick;

    // Top bit of this word from the previous iteration: the neighbour's
    // fresh sum bit 0, or for the highest word its own stored carry.
    assign top_bit = TOP ? carry_q[0] : nb_in;

    always_comb begin
        part   = {3'b000, sh_q}
               + (step.xbit ? SW'(y_word) : '0)
               + (step.qbit ? SW'(m_word) : '0)
               + SW'(cin);
        sum_lo = part;
        sum_hi = part + (SW'(1) << (W - 1));
        pick   = top_bit ? sum_hi : sum_lo;
    end

    // Bit 0 does not depend on the pending top bit, so it can be offered
    // to the lower neighbour within the same cycle.
    assign lsb_out = step.valid & sum_lo[0];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sh_q    <= '0;
            carry_q <= '0;
            lsb_q   <= 1'b0;
        end else if (step.valid) begin
            sh_q    <= pick[W:1];
            carry_q <= pick[W+1:W];
            lsb_q   <= pick[0];
        end
    end

    if (TOP) begin : g_top_chk
        // R1: with X, Y < M the highest word never carries past one bit.
        a_r1_top_carry_narrow: assert property (@(posedge clk) disable iff (rst)
            step.valid |=> (carry_q[1] == 1'b0));
    end

endmodule

// File: rtl/mont_final_reduce.sv
module mont_final_reduce #(
    parameter int N  = 64,
    parameter int SW = 81
) (
    input  logic [SW-1:0] s_val,
    input  logic [N-1:0]  m_val,
    output logic [N-1:0]  res
);
    logic [SW-1:0] m_ext;
    logic [N-1:0]  diff_lo;
    logic          ge;

    always_comb begin
        m_ext   = SW'(m_val);
        ge      = (s_val >= m_ext);
        diff_lo = N'(s_val - m_ext);
        res     = ge ? diff_lo : s_val[N-1:0];
    end

endmodule

// File: rtl/mont_wp_mul.sv
module mont_wp_mul
    import mont_pkg::*;
#(
    parameter int N = 64,
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [N-1:0] x_in,
    input  logic [N-1:0] y_in,
    input  logic [N-1:0] m_in,
    output logic         done,
    output logic [N-1:0] result
);
    localparam int E   = word_count(N, W);
    localparam int EW  = E * W;
    localparam int SW  = EW + 1;
    localparam int LAT = N + E - 1;
    localparam int LCW = $clog2(LAT + 2);

    logic          busy;
    logic          accept;
    logic [EW-1:0] y_reg;
    logic [EW-1:0] m_reg;
    step_t [E-1:0] steps;

    logic [1:0]    carry  [E];
    logic [W-2:0]  sh     [E];
    logic          lsb_q  [E];
    logic          lsb_out[E];
    logic [SW-1:0] s_full;

    assign accept = start & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            y_reg <= '0;
            m_reg <= '0;
        end else begin
            done <= steps[E-1].last;
            if (accept) begin
                busy  <= 1'b1;
                y_reg <= EW'(y_in);
                m_reg <= EW'(m_in);
            end else if (steps[E-1].last) begin
                busy <= 1'b0;
            end
        end
    end

    mont_step_feed #(.N(N), .E(E)) u_feed (
        .clk    (clk),
        .rst    (rst),
        .load   (accept),
        .x_val  (x_in),
        .s0_lsb (sh[0][0]),
        .y0_lsb (y_reg[0]),
        .steps  (steps)
    );

    for (genvar j = 0; j < E; j++) begin : g_pe
        logic [1:0] cin_w;
        logic       nb_w;

        if (j == 0) begin : g_cin0
            assign cin_w = 2'b00;
        end else begin : g_cinj
            assign cin_w = carry[j-1];
        end

        if (j == E - 1) begin : g_hi
            assign nb_w = 1'b0;
            assign s_full[SW-1 -: W+1] = {carry[j], sh[j]};
        end else begin : g_mid
            assign nb_w = lsb_out[j+1];
            assign s_full[j*W +: W] = {lsb_q[j+1], sh[j]};
        end

        mont_word_pe #(.W(W), .TOP(j == E - 1)) u_pe (
            .clk     (clk),
            .rst     (rst),
            .clr     (accept),
            .step    (steps[j]),
            .y_word  (y_reg[j*W +: W]),
            .m_word  (m_reg[j*W +: W]),
            .cin     (cin_w),
            .nb_in   (nb_w),
            .lsb_out (lsb_out[j]),
            .carry_q (carry[j]),
            .sh_q    (sh[j]),
            .lsb_q   (lsb_q[j])
        );
    end

    mont_final_reduce #(.N(N), .SW(SW)) u_reduce (
        .s_val (s_full),
        .m_val (m_reg[N-1:0]),
        .res   (result)
    );

    // Cycle count since the accepting edge, kept for the latency check.
    logic [LCW-1:0] lat_cnt;
    always_ff @(posedge clk) begin
        if (rst)         lat_cnt <= '0;
        else if (accept) lat_cnt <= '0;
        else if (busy)   lat_cnt <= lat_cnt + 1'b1;
    end

    // R3: single-cycle completion pulse.
    a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: completion lands exactly N+E-1 edges after acceptance.
    a_r3_latency: assert property (@(posedge clk) disable iff (rst)
        done |-> (lat_cnt == LCW'(LAT)));

    // R1: the Montgomery step always leaves word 0 even.
    a_r1_word0_even: assert property (@(posedge clk) disable iff (rst)
        (steps[0].valid && !accept) |=> (lsb_q[0] == 1'b0));

    // R1: the value presented at completion is fully reduced.
    a_r1_reduced: assert property (@(posedge clk) disable iff (rst)
        done |-> (result < m_reg[N-1:0]));

    // R4: a request during a run leaves the captured operands alone.
    a_r4_busy_ignore: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(m_reg) && $stable(y_reg)));

    // R5: while idle with no request, the output does not move.
    a_r5_result_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(result));

endmodule

// File: tb/tb_mont_wp_mul.sv
module tb_mont_wp_mul;
    localparam int N   = 64;
    localparam int W   = 16;
    localparam int E   = (N + W) / W;
    localparam int LAT = N + E - 1;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic [N-1:0] x_in, y_in, m_in;
    logic         done;
    logic [N-1:0] result;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mont_wp_mul #(.N(N), .W(W)) dut (
        .clk(clk), .rst(rst), .start(start),
        .x_in(x_in), .y_in(y_in), .m_in(m_in),
        .done(done), .result(result)
    );

    // Reference: (X*Y mod M) times the inverse of 2^N, found by halving mod M.
    function automatic logic [N-1:0] ref_mont(input logic [N-1:0] x,
                                               input logic [N-1:0] y,
                                               input logic [N-1:0] m);
        logic [2*N-1:0] p, h, mm;
        mm = (2*N)'(m);
        p  = ((2*N)'(x) * (2*N)'(y)) % mm;
        h  = (2*N)'(1) % mm;
        for (int k = 0; k < N; k++)
            h = h[0] ? ((h + mm) >> 1) : (h >> 1);
        p = (p * h) % mm;
        return p[N-1:0];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    function automatic logic [N-1:0] rnd64();
        return {$urandom(), $urandom()};
    endfunction

    // Called at a falling edge; returns at the falling edge where done is seen.
    task automatic run_op(input logic [N-1:0] x, input logic [N-1:0] y,
                          input logic [N-1:0] m,
                          output logic [N-1:0] res, output int lat);
        x_in = x; y_in = y; m_in = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 400) begin
            @(negedge clk);
            lat++;
        end
        res = result;
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; x_in = '0; y_in = '0; m_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 1'b0, "R6", "done after reset", N'(done), '0);
        chk(result == '0, "R6", "result after reset", result, '0);
    endtask

    task automatic t_directed();
        logic [N-1:0] r;
        int lat;
        logic [N-1:0] mx;
        mx = '1;
        run_op(64'd0, 64'd5, 64'd7, r, lat);
        chk(r == '0, "R8", "zero X", r, '0);
        chk(lat == LAT, "R3", "latency zero X", N'(lat), N'(LAT));
        run_op(64'd3, 64'd0, 64'd11, r, lat);
        chk(r == '0, "R8", "zero Y", r, '0);
        run_op(64'd0, 64'd0, 64'd1, r, lat);
        chk(r == '0, "R8", "modulus one", r, '0);
        run_op(64'd3, 64'd5, 64'd7, r, lat);
        chk(r == ref_mont(64'd3, 64'd5, 64'd7), "R1", "small modulus", r,
            ref_mont(64'd3, 64'd5, 64'd7));
        run_op(mx - 1, mx - 1, mx, r, lat);
        chk(r == ref_mont(mx - 1, mx - 1, mx), "R1", "largest modulus", r,
            ref_mont(mx - 1, mx - 1, mx));
        chk(lat == LAT, "R3", "latency largest modulus", N'(lat), N'(LAT));
        run_op(64'd1, 64'd1, 64'h8000_0000_0000_0001, r, lat);
        chk(r == ref_mont(64'd1, 64'd1, 64'h8000_0000_0000_0001), "R1",
            "unit operands", r, ref_mont(64'd1, 64'd1, 64'h8000_0000_0000_0001));
    endtask

    task automatic t_pulse();
        logic [N-1:0] r;
        int lat;
        run_op(64'd9, 64'd4, 64'd13, r, lat);
        chk(done == 1'b1, "R3", "done seen", N'(done), 64'd1);
        @(negedge clk);
        chk(done == 1'b0, "R3", "done drops after one cycle", N'(done), '0);
    endtask

    task automatic t_random(input int count);
        logic [N-1:0] r, m, x, y, e;
        int lat;
        for (int k = 0; k < count; k++) begin
            m = rnd64() | 64'd1;
            if (k % 3 == 0) m[N-1] = 1'b1;
            x = rnd64() % m;
            y = rnd64() % m;
            e = ref_mont(x, y, m);
            run_op(x, y, m, r, lat);
            chk(r == e, "R1", "random product", r, e);
            chk(lat == LAT, "R3", "random latency", N'(lat), N'(LAT));
        end
    endtask

    task automatic t_back2back();
        logic [N-1:0] r1, r2;
        int lat1, lat2;
        run_op(64'h1234_5678_9abc_def0, 64'h0fed_cba9_8765_4321,
               64'hffff_ffff_ffff_ffc5, r1, lat1);
        // start again in the very cycle done is high
        run_op(64'h0000_0000_dead_beef, 64'h0000_1111_2222_3333,
               64'hc000_0000_0000_0007, r2, lat2);
        chk(r2 == ref_mont(64'h0000_0000_dead_beef, 64'h0000_1111_2222_3333,
                           64'hc000_0000_0000_0007),
            "R7", "start in done cycle result", r2,
            ref_mont(64'h0000_0000_dead_beef, 64'h0000_1111_2222_3333,
                     64'hc000_0000_0000_0007));
        chk(lat2 == LAT, "R7", "start in done cycle latency", N'(lat2), N'(LAT));
        @(negedge clk);
    endtask

    task automatic t_busy_ignore();
        logic [N-1:0] xa, ya, ma, e;
        int k;
        int extra;
        xa = 64'h0123_4567_89ab_cdef; ya = 64'h7654_3210_fedc_ba98;
        ma = 64'hfedc_ba98_7654_3211;
        e  = ref_mont(xa, ya, ma);
        x_in = xa; y_in = ya; m_in = ma; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: operands change on the pins right after acceptance
        x_in = 64'h5; y_in = 64'h9; m_in = 64'h1f;
        k = 0;
        repeat (10) begin @(negedge clk); k++; end
        // R4: second request while busy
        x_in = 64'hffff; y_in = 64'h3; m_in = 64'h10001; start = 1'b1;
        @(negedge clk); k++;
        start = 1'b0;
        while (!done && k < 400) begin @(negedge clk); k++; end
        chk(result == e, "R2", "operands taken at accepting edge", result, e);
        chk(k == LAT, "R4", "no restart on busy start", N'(k), N'(LAT));
        extra = 0;
        repeat (LAT + 8) begin
            @(negedge clk);
            if (done) extra++;
        end
        chk(extra == 0, "R4", "single done pulse", N'(extra), '0);
        chk(result == e, "R4", "result of first operands kept", result, e);
    endtask

    task automatic t_hold();
        logic [N-1:0] r, e;
        int lat;
        e = ref_mont(64'd123456789, 64'd987654321, 64'h0000_7fff_ffff_ffff);
        run_op(64'd123456789, 64'd987654321, 64'h0000_7fff_ffff_ffff, r, lat);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            x_in = rnd64(); y_in = rnd64(); m_in = rnd64() | 64'd1;
        end
        chk(result == e, "R5", "result held while idle", result, e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        t_reset();
        t_directed();
        t_pulse();
        t_random(30);
        t_back2back();
        t_busy_ignore();
        t_hold();
        summary();
        $finish;
    end

endmodule